// File: doc/BRIEF.md
# Serial FIFO Pair with Threshold Interrupts and DMA Requests

This block holds the transmit and receive FIFOs of a serial controller and turns their fill levels into interrupt and DMA request signals. The bus side pushes words into the transmit FIFO and pops words from the receive FIFO. The serial engine pops the transmit FIFO and pushes the receive FIFO. The block reports both fill levels and a five-bit status word. It keeps a five-bit interrupt vector that can be read raw, masked and as a single interrupt line. It also drives one DMA request line for each direction.

Software programs four thresholds: a transmit interrupt threshold, a receive interrupt threshold, a transmit DMA level and a receive DMA level. A threshold is only stored when the written value is smaller than the FIFO depth. Software can therefore find the depth by writing rising values and reading them back. Overflow and underflow events are held in sticky flags. Software clears them with a four-bit clear word that can target one flag or all of them. Register address decode is done outside the block: each register has its own write strobe and read-back port.

Top module: `xfe_top`

## Requirements
- R1: After a synchronous reset the following hold. Both levels read 0, and all thresholds, the interrupt mask, the DMA enables and the sticky flags read 0. The status word reads 5'b01100. The raw interrupt vector reads 5'b00001. `masked_int`, `irq`, `tx_dma_req` and `rx_dma_req` read 0.
- R2: Each FIFO returns words in the order they were accepted, and its read data port shows the oldest word. On the edge that samples them, an accepted push raises the level by one and an accepted pop lowers it by one. An accepted push and an accepted pop in the same cycle leave the level unchanged.
- R3: The status word `status` has these bits. Bit 0 is busy: the `engine_busy` input OR'd with "transmit FIFO not empty". Bit 1 is transmit full. Bit 2 is transmit empty. Bit 3 is receive empty. Bit 4 is receive full.
- R4: A push to a full FIFO is dropped, and the level and contents of that FIFO do not change. After the edge, a dropped transmit push sets raw bit 1 (transmit overflow) and a dropped receive push sets raw bit 3 (receive overflow).
- R5: A pop from an empty FIFO is dropped. After the edge, a dropped receive pop sets raw bit 2 (receive underflow). A dropped transmit pop sets no flag.
- R6: Raw bits 1 to 3 are sticky until cleared by a `clr_we` strobe. The clear word has these bits:
  - Bit 0 clears all three flags.
  - Bit 1 clears receive underflow.
  - Bit 2 clears receive overflow.
  - Bit 3 clears transmit overflow.

  A flag that the clear word does not select keeps its value. If a new event arrives in the same cycle as a clear of its flag, the flag stays set.
- R7: Raw bit 0 is 1 while the transmit level is at or below the transmit interrupt threshold. Raw bit 4 is 1 while the receive level is above the receive interrupt threshold.
- R8: `masked_int` is `raw_int` AND `int_mask`, where a mask bit of 1 enables that interrupt. `irq` is the OR of the `masked_int` bits. The mask takes the value of `mask_wdata` on the edge that samples `mask_we`.
- R9: `thr_sel` selects the threshold for a `thr_we` write:
  - 0 selects the transmit interrupt threshold.
  - 1 selects the receive interrupt threshold.
  - 2 selects the transmit DMA level.
  - 3 selects the receive DMA level.

  A value below DEPTH is stored. A value at or above DEPTH leaves the register unchanged.
- R10: `tx_dma_req` is DMA enable bit 1 AND (transmit level at or below the transmit DMA level). `rx_dma_req` is DMA enable bit 0 AND (receive level above the receive DMA level). The enables take the value of `dmaen_wdata` on the edge that samples `dmaen_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_push | input | 1 | Bus side writes a word into the transmit FIFO |
| tx_wdata | input | DATA_W | Word to write into the transmit FIFO |
| tx_pop | input | 1 | Serial engine takes a word from the transmit FIFO |
| tx_rdata | output | DATA_W | Oldest word in the transmit FIFO |
| rx_push | input | 1 | Serial engine writes a word into the receive FIFO |
| rx_wdata | input | DATA_W | Word to write into the receive FIFO |
| rx_pop | input | 1 | Bus side takes a word from the receive FIFO |
| rx_rdata | output | DATA_W | Oldest word in the receive FIFO |
| engine_busy | input | 1 | Serial engine is shifting |
| thr_we | input | 1 | Threshold write strobe |
| thr_sel | input | 2 | Threshold select (see R9) |
| thr_wdata | input | LW | Threshold write value |
| mask_we | input | 1 | Interrupt mask write strobe |
| mask_wdata | input | 5 | Interrupt mask value |
| clr_we | input | 1 | Flag clear strobe |
| clr_wdata | input | 4 | Flag clear word (see R6) |
| dmaen_we | input | 1 | DMA enable write strobe |
| dmaen_wdata | input | 2 | DMA enables: bit 0 receive, bit 1 transmit |
| tx_irq_thr | output | LW | Transmit interrupt threshold read-back |
| rx_irq_thr | output | LW | Receive interrupt threshold read-back |
| tx_dma_lvl | output | LW | Transmit DMA level read-back |
| rx_dma_lvl | output | LW | Receive DMA level read-back |
| int_mask | output | 5 | Interrupt mask read-back |
| dma_en | output | 2 | DMA enables read-back |
| tx_level | output | LW | Transmit FIFO fill level |
| rx_level | output | LW | Receive FIFO fill level |
| status | output | 5 | Status word (see R3) |
| raw_int | output | 5 | Raw interrupt vector |
| masked_int | output | 5 | Masked interrupt vector |
| irq | output | 1 | Interrupt line |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

LW is $clog2(DEPTH+1).

## Verification
The hardest case to reach from the ports is a flag event and a clear of that same flag in one cycle. To get there, the stimulus first fills the receive FIFO to its depth. It then drives a further receive push and a clear of receive overflow on the same clock edge, and checks that the flag survives. The dropped pushes must not reach the data path. The transmit FIFO is therefore filled, pushed once more while full, and then drained. The scoreboard checks that only the accepted words come out, in their original order.

// File: rtl/xfe_pkg.sv
package xfe_pkg;

    // status word bit positions
    localparam int ST_BUSY     = 0;
    localparam int ST_TX_FULL  = 1;
    localparam int ST_TX_EMPTY = 2;
    localparam int ST_RX_EMPTY = 3;
    localparam int ST_RX_FULL  = 4;

    // interrupt vector bit positions
    localparam int IR_TX_LOW  = 0;
    localparam int IR_TX_OVF  = 1;
    localparam int IR_RX_UNF  = 2;
    localparam int IR_RX_OVF  = 3;
    localparam int IR_RX_HIGH = 4;

    // clear word bit positions
    localparam int CL_ALL    = 0;
    localparam int CL_RX_UNF = 1;
    localparam int CL_RX_OVF = 2;
    localparam int CL_TX_OVF = 3;

    // DMA enable bit positions
    localparam int DE_RX = 0;
    localparam int DE_TX = 1;

    localparam int NUM_THR = 4;

    typedef enum logic [1:0] {
        THR_TX_IRQ = 2'd0,
        THR_RX_IRQ = 2'd1,
        THR_TX_DMA = 2'd2,
        THR_RX_DMA = 2'd3
    } thr_sel_e;

    typedef struct packed {
        logic full;
        logic empty;
    } fifo_flags_t;

    // field order gives bit 4 down to bit 0
    typedef struct packed {
        logic rx_high;
        logic rx_ovf;
        logic rx_unf;
        logic tx_ovf;
        logic tx_low;
    } irq_vec_t;

    typedef struct packed {
        logic rx_full;
        logic rx_empty;
        logic tx_empty;
        logic tx_full;
        logic busy;
    } status_t;

    // next value of a sticky flag: a new event wins over a clear
    function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
        return set | (cur & ~clr);
    endfunction

endpackage

// File: rtl/xfe_fifo.sv
module xfe_fifo
    import xfe_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic [LW-1:0]     level,
    output fifo_flags_t       flags
);

    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr;
    logic [AW-1:0]     rptr;
    logic [LW-1:0]     count;
    logic              push_ok;
    logic              pop_ok;

    assign push_ok = push && (count != FULL_LVL);
    assign pop_ok  = pop && (count != '0);

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) begin
                wptr <= (wptr == LAST_IDX) ? '0 : wptr + AW'(1);
            end
            if (pop_ok) begin
                rptr <= (rptr == LAST_IDX) ? '0 : rptr + AW'(1);
            end
            case ({push_ok, pop_ok})
                2'b10:   count <= count + LW'(1);
                2'b01:   count <= count - LW'(1);
                default: count <= count;
            endcase
        end
    end

    assign rdata       = mem[rptr];
    assign level       = count;
    assign flags.full  = (count == FULL_LVL);
    assign flags.empty = (count == '0);

    // R2: the level never exceeds the depth
    a_r2_level_bound: assert property (@(posedge clk) disable iff (rst)
        level <= FULL_LVL);

    // R4: a push while full and without a pop leaves the FIFO full
    a_r4_full_push_dropped: assert property (@(posedge clk) disable iff (rst)
        (flags.full && push && !pop) |=> flags.full);

    // R5: a pop while empty and without a push leaves the FIFO empty
    a_r5_empty_pop_dropped: assert property (@(posedge clk) disable iff (rst)
        (flags.empty && pop && !push) |=> flags.empty);

endmodule

// File: rtl/xfe_thr_bank.sv
module xfe_thr_bank
    import xfe_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  thr_sel_e                  sel,
    input  logic [LW-1:0]             wdata,
    output logic [NUM_THR-1:0][LW-1:0] thr
);

    localparam logic [LW-1:0] LIMIT = LW'(DEPTH);

    logic fits;
    assign fits = (wdata < LIMIT);

    for (genvar i = 0; i < NUM_THR; i++) begin : g_thr
        logic [LW-1:0] q;
        logic          hit;

        assign hit = we && (sel == thr_sel_e'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (hit && fits) begin
                q <= wdata;
            end
        end

        assign thr[i] = q;

        // R9: a stored threshold is always below the depth
        a_r9_thr_in_range: assert property (@(posedge clk) disable iff (rst)
            thr[i] < LIMIT);

        // R9: an out-of-range write leaves the register unchanged
        a_r9_reject_hold: assert property (@(posedge clk) disable iff (rst)
            (hit && !fits) |=> $stable(thr[i]));
    end

endmodule

// File: rtl/xfe_irq_dma.sv
module xfe_irq_dma
    import xfe_pkg::*;
#(
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [LW-1:0] tx_level,
    input  logic [LW-1:0] rx_level,
    input  logic [LW-1:0] tx_irq_thr,
    input  logic [LW-1:0] rx_irq_thr,
    input  logic [LW-1:0] tx_dma_lvl,
    input  logic [LW-1:0] rx_dma_lvl,
    input  logic          tx_push,
    input  logic          rx_push,
    input  logic          rx_pop,
    input  fifo_flags_t   tx_flags,
    input  fifo_flags_t   rx_flags,
    input  logic          mask_we,
    input  logic [4:0]    mask_wdata,
    input  logic          clr_we,
    input  logic [3:0]    clr_wdata,
    input  logic          dmaen_we,
    input  logic [1:0]    dmaen_wdata,
    output irq_vec_t      raw,
    output irq_vec_t      masked,
    output logic [4:0]    mask,
    output logic [1:0]    dma_en,
    output logic          irq,
    output logic          tx_dma_req,
    output logic          rx_dma_req
);

    logic tx_ovf_q, rx_ovf_q, rx_unf_q;
    logic tx_ovf_ev, rx_ovf_ev, rx_unf_ev;
    logic clr_tx_ovf, clr_rx_ovf, clr_rx_unf;
    logic [4:0] mask_q;
    logic [1:0] den_q;

    assign tx_ovf_ev = tx_push && tx_flags.full;
    assign rx_ovf_ev = rx_push && rx_flags.full;
    assign rx_unf_ev = rx_pop && rx_flags.empty;

    assign clr_tx_ovf = clr_we && (clr_wdata[CL_ALL] || clr_wdata[CL_TX_OVF]);
    assign clr_rx_ovf = clr_we && (clr_wdata[CL_ALL] || clr_wdata[CL_RX_OVF]);
    assign clr_rx_unf = clr_we && (clr_wdata[CL_ALL] || clr_wdata[CL_RX_UNF]);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_ovf_q <= 1'b0;
            rx_ovf_q <= 1'b0;
            rx_unf_q <= 1'b0;
            mask_q   <= '0;
            den_q    <= '0;
        end else begin
            tx_ovf_q <= sticky_next(tx_ovf_q, tx_ovf_ev, clr_tx_ovf);
            rx_ovf_q <= sticky_next(rx_ovf_q, rx_ovf_ev, clr_rx_ovf);
            rx_unf_q <= sticky_next(rx_unf_q, rx_unf_ev, clr_rx_unf);
            if (mask_we) begin
                mask_q <= mask_wdata;
            end
            if (dmaen_we) begin
                den_q <= dmaen_wdata;
            end
        end
    end

    always_comb begin
        raw.tx_low  = (tx_level <= tx_irq_thr);
        raw.tx_ovf  = tx_ovf_q;
        raw.rx_unf  = rx_unf_q;
        raw.rx_ovf  = rx_ovf_q;
        raw.rx_high = (rx_level > rx_irq_thr);
    end

    assign masked     = irq_vec_t'(raw & mask_q);
    assign irq        = |masked;
    assign mask       = mask_q;
    assign dma_en     = den_q;
    assign tx_dma_req = den_q[DE_TX] && (tx_level <= tx_dma_lvl);
    assign rx_dma_req = den_q[DE_RX] && (rx_level > rx_dma_lvl);

    // R4: transmit overflow only rises after a push into a full FIFO
    a_r4_tx_ovf_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(raw.tx_ovf) |-> $past(tx_push && tx_flags.full));

    // R6: an uncleared sticky flag stays set
    a_r6_tx_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (raw.tx_ovf && !clr_tx_ovf) |=> raw.tx_ovf);

    a_r6_rx_unf_sticky: assert property (@(posedge clk) disable iff (rst)
        (raw.rx_unf && !clr_rx_unf) |=> raw.rx_unf);

    // R6: an event in the same cycle as its clear keeps the flag set
    a_r6_event_wins: assert property (@(posedge clk) disable iff (rst)
        (rx_push && rx_flags.full && clr_rx_ovf) |=> raw.rx_ovf);

    // R8: the line can only be active while some mask bit is set
    a_r8_irq_needs_mask: assert property (@(posedge clk) disable iff (rst)
        irq |-> (mask != '0));

endmodule

// File: rtl/xfe_top.sv
module xfe_top
    import xfe_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_rdata,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_wdata,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_rdata,
    input  logic              engine_busy,
    input  logic              thr_we,
    input  logic [1:0]        thr_sel,
    input  logic [LW-1:0]     thr_wdata,
    input  logic              mask_we,
    input  logic [4:0]        mask_wdata,
    input  logic              clr_we,
    input  logic [3:0]        clr_wdata,
    input  logic              dmaen_we,
    input  logic [1:0]        dmaen_wdata,
    output logic [LW-1:0]     tx_irq_thr,
    output logic [LW-1:0]     rx_irq_thr,
    output logic [LW-1:0]     tx_dma_lvl,
    output logic [LW-1:0]     rx_dma_lvl,
    output logic [4:0]        int_mask,
    output logic [1:0]        dma_en,
    output logic [LW-1:0]     tx_level,
    output logic [LW-1:0]     rx_level,
    output logic [4:0]        status,
    output logic [4:0]        raw_int,
    output logic [4:0]        masked_int,
    output logic              irq,
    output logic              tx_dma_req,
    output logic              rx_dma_req
);

    fifo_flags_t                 tx_flags;
    fifo_flags_t                 rx_flags;
    logic [NUM_THR-1:0][LW-1:0]  thr;
    irq_vec_t                    raw_v;
    irq_vec_t                    masked_v;
    status_t                     st;

    xfe_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (tx_push),
        .wdata (tx_wdata),
        .pop   (tx_pop),
        .rdata (tx_rdata),
        .level (tx_level),
        .flags (tx_flags)
    );

    xfe_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (rx_push),
        .wdata (rx_wdata),
        .pop   (rx_pop),
        .rdata (rx_rdata),
        .level (rx_level),
        .flags (rx_flags)
    );

    xfe_thr_bank #(.DEPTH(DEPTH)) u_thr (
        .clk   (clk),
        .rst   (rst),
        .we    (thr_we),
        .sel   (thr_sel_e'(thr_sel)),
        .wdata (thr_wdata),
        .thr   (thr)
    );

    assign tx_irq_thr = thr[THR_TX_IRQ];
    assign rx_irq_thr = thr[THR_RX_IRQ];
    assign tx_dma_lvl = thr[THR_TX_DMA];
    assign rx_dma_lvl = thr[THR_RX_DMA];

    xfe_irq_dma #(.LW(LW)) u_evt (
        .clk         (clk),
        .rst         (rst),
        .tx_level    (tx_level),
        .rx_level    (rx_level),
        .tx_irq_thr  (tx_irq_thr),
        .rx_irq_thr  (rx_irq_thr),
        .tx_dma_lvl  (tx_dma_lvl),
        .rx_dma_lvl  (rx_dma_lvl),
        .tx_push     (tx_push),
        .rx_push     (rx_push),
        .rx_pop      (rx_pop),
        .tx_flags    (tx_flags),
        .rx_flags    (rx_flags),
        .mask_we     (mask_we),
        .mask_wdata  (mask_wdata),
        .clr_we      (clr_we),
        .clr_wdata   (clr_wdata),
        .dmaen_we    (dmaen_we),
        .dmaen_wdata (dmaen_wdata),
        .raw         (raw_v),
        .masked      (masked_v),
        .mask        (int_mask),
        .dma_en      (dma_en),
        .irq         (irq),
        .tx_dma_req  (tx_dma_req),
        .rx_dma_req  (rx_dma_req)
    );

    always_comb begin
        st.busy     = engine_busy || !tx_flags.empty;
        st.tx_full  = tx_flags.full;
        st.tx_empty = tx_flags.empty;
        st.rx_empty = rx_flags.empty;
        st.rx_full  = rx_flags.full;
    end

    assign status     = st;
    assign raw_int    = raw_v;
    assign masked_int = masked_v;

    // R10: a receive request implies the receive FIFO holds data
    a_r10_rx_req_has_data: assert property (@(posedge clk) disable iff (rst)
        rx_dma_req |-> (rx_level != '0));

    // R10: a transmit request implies the transmit FIFO has room
    a_r10_tx_req_has_room: assert property (@(posedge clk) disable iff (rst)
        tx_dma_req |-> !tx_flags.full);

    // R3: full and empty are never reported together
    a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(status[ST_TX_FULL] && status[ST_TX_EMPTY]) && !(status[ST_RX_FULL] && status[ST_RX_EMPTY]));

endmodule

// File: tb/sim_xfe_top.sv
`timescale 1ns/1ps
module sim_xfe_top;

    localparam int DATA_W = 16;
    localparam int DEPTH  = 8;
    localparam int LW     = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
    logic [DATA_W-1:0] tx_wdata = '0, rx_wdata = '0;
    logic [DATA_W-1:0] tx_rdata, rx_rdata;
    logic              engine_busy = 0;
    logic              thr_we = 0;
    logic [1:0]        thr_sel = '0;
    logic [LW-1:0]     thr_wdata = '0;
    logic              mask_we = 0;
    logic [4:0]        mask_wdata = '0;
    logic              clr_we = 0;
    logic [3:0]        clr_wdata = '0;
    logic              dmaen_we = 0;
    logic [1:0]        dmaen_wdata = '0;
    logic [LW-1:0]     tx_irq_thr, rx_irq_thr, tx_dma_lvl, rx_dma_lvl;
    logic [4:0]        int_mask;
    logic [1:0]        dma_en;
    logic [LW-1:0]     tx_level, rx_level;
    logic [4:0]        status, raw_int, masked_int;
    logic              irq, tx_dma_req, rx_dma_req;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 0;

    logic [DATA_W-1:0] txq[$];
    logic [DATA_W-1:0] rxq[$];

    always #5 clk = ~clk;

    xfe_top #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
        .engine_busy(engine_busy),
        .thr_we(thr_we), .thr_sel(thr_sel), .thr_wdata(thr_wdata),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .clr_we(clr_we), .clr_wdata(clr_wdata),
        .dmaen_we(dmaen_we), .dmaen_wdata(dmaen_wdata),
        .tx_irq_thr(tx_irq_thr), .rx_irq_thr(rx_irq_thr),
        .tx_dma_lvl(tx_dma_lvl), .rx_dma_lvl(rx_dma_lvl),
        .int_mask(int_mask), .dma_en(dma_en),
        .tx_level(tx_level), .rx_level(rx_level),
        .status(status), .raw_int(raw_int), .masked_int(masked_int),
        .irq(irq), .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: compares popped words against the scoreboard (R2)
    always @(posedge clk) begin
        if (!rst && tx_pop && txq.size() > 0) begin
            chk("R2 tx order", int'(tx_rdata), int'(txq.pop_front()));
        end
        if (!rst && rx_pop && rxq.size() > 0) begin
            chk("R2 rx order", int'(rx_rdata), int'(rxq.pop_front()));
        end
    end

    // drivers: the scoreboard takes a word only when the FIFO has room
    task automatic push_tx(input logic [DATA_W-1:0] d);
        tx_push = 1; tx_wdata = d;
        if (txq.size() < DEPTH) txq.push_back(d);
        @(negedge clk);
        tx_push = 0;
    endtask

    task automatic pop_tx();
        tx_pop = 1;
        @(negedge clk);
        tx_pop = 0;
    endtask

    task automatic push_rx(input logic [DATA_W-1:0] d);
        rx_push = 1; rx_wdata = d;
        if (rxq.size() < DEPTH) rxq.push_back(d);
        @(negedge clk);
        rx_push = 0;
    endtask

    task automatic pop_rx();
        rx_pop = 1;
        @(negedge clk);
        rx_pop = 0;
    endtask

    task automatic thr_w(input logic [1:0] s, input logic [LW-1:0] v);
        thr_we = 1; thr_sel = s; thr_wdata = v;
        @(negedge clk);
        thr_we = 0;
    endtask

    task automatic mask_w(input logic [4:0] v);
        mask_we = 1; mask_wdata = v;
        @(negedge clk);
        mask_we = 0;
    endtask

    task automatic clr_w(input logic [3:0] v);
        clr_we = 1; clr_wdata = v;
        @(negedge clk);
        clr_we = 0;
    endtask

    task automatic den_w(input logic [1:0] v);
        dmaen_we = 1; dmaen_wdata = v;
        @(negedge clk);
        dmaen_we = 0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        chk("R1 tx_level", tx_level, 0);
        chk("R1 rx_level", rx_level, 0);
        chk("R1 status", status, 5'b01100);
        chk("R1 raw", raw_int, 5'b00001);
        chk("R1 masked", masked_int, 0);
        chk("R1 irq", irq, 0);
        chk("R1 dma reqs", {tx_dma_req, rx_dma_req}, 0);
        chk("R1 thresholds", {tx_irq_thr, rx_irq_thr, tx_dma_lvl, rx_dma_lvl}, 0);
        chk("R1 mask/dma_en", {int_mask, dma_en}, 0);

        // R3 busy follows engine_busy
        engine_busy = 1;
        #1 chk("R3 busy from engine", status, 5'b01101);
        engine_busy = 0;
        @(negedge clk);

        // R2 ordered push and pop
        push_tx(16'h00A1); push_tx(16'h00A2); push_tx(16'h00A3);
        chk("R2 tx level 3", tx_level, 3);
        chk("R3 status tx non-empty busy", status, 5'b01001);
        chk("R7 tx above thr", raw_int[0], 0);
        repeat (3) pop_tx();
        chk("R2 tx drained", tx_level, 0);

        // R2 simultaneous push and pop
        push_tx(16'h00B1); push_tx(16'h00B2);
        tx_push = 1; tx_wdata = 16'h00B3; tx_pop = 1;
        txq.push_back(16'h00B3);
        @(negedge clk);
        tx_push = 0; tx_pop = 0;
        chk("R2 push+pop keeps level", tx_level, 2);
        repeat (2) pop_tx();

        // R3/R4 fill TX then push into full
        for (int i = 0; i < DEPTH; i++) push_tx(DATA_W'(16'h0C00 + i));
        chk("R3 tx full status", status, 5'b01011);
        push_tx(16'hDEAD);
        chk("R4 tx level unchanged", tx_level, DEPTH);
        chk("R4 tx overflow flag", raw_int[1], 1);
        for (int i = 0; i < DEPTH; i++) pop_tx();
        chk("R4 scoreboard empty", txq.size(), 0);

        // R5 pop empty TX: no flag
        pop_tx();
        chk("R5 tx empty pop", tx_level, 0);
        chk("R5 no tx underflow flag", raw_int, 5'b00011);

        // R5 pop empty RX sets underflow
        pop_rx();
        chk("R5 rx underflow", raw_int, 5'b00111);

        // R4 fill RX and overflow
        for (int i = 0; i < DEPTH; i++) push_rx(DATA_W'(16'h0D00 + i));
        chk("R3 rx full status", status, 5'b10100);
        push_rx(16'hBEEF);
        chk("R4 rx overflow", raw_int, 5'b11111);
        chk("R4 rx level unchanged", rx_level, DEPTH);

        // R6 selective clears
        clr_w(4'b0010);
        chk("R6 clear rx underflow only", raw_int, 5'b11011);
        rx_push = 1; rx_wdata = 16'hFACE; clr_we = 1; clr_wdata = 4'b0100;
        @(negedge clk);
        rx_push = 0; clr_we = 0;
        chk("R6 event wins over clear", raw_int, 5'b11011);
        clr_w(4'b1000);
        chk("R6 clear tx overflow", raw_int, 5'b11001);
        clr_w(4'b0001);
        chk("R6 clear all", raw_int, 5'b10001);
        @(negedge clk);
        chk("R6 stays cleared", raw_int, 5'b10001);

        // R9 threshold range
        thr_w(2'd0, LW'(DEPTH));
        chk("R9 reject depth", tx_irq_thr, 0);
        thr_w(2'd0, 3);
        chk("R9 accept 3", tx_irq_thr, 3);
        thr_w(2'd0, 15);
        chk("R9 reject 15 keeps 3", tx_irq_thr, 3);
        thr_w(2'd1, LW'(DEPTH - 1));
        chk("R9 accept max", rx_irq_thr, DEPTH - 1);
        thr_w(2'd1, 2);
        thr_w(2'd2, 5);
        thr_w(2'd3, 4);
        thr_w(2'd3, LW'(DEPTH));
        chk("R9 selects", {tx_irq_thr, rx_irq_thr, tx_dma_lvl, rx_dma_lvl},
            {4'd3, 4'd2, 4'd5, 4'd4});

        // R7 level comparisons
        chk("R7 rx 8 above 2", raw_int[4], 1);
        repeat (5) pop_rx();
        chk("R7 rx 3 above 2", raw_int[4], 1);
        pop_rx();
        chk("R7 rx 2 not above 2", raw_int[4], 0);
        for (int i = 0; i < 4; i++) push_tx(DATA_W'(16'h0E00 + i));
        chk("R7 tx 4 above 3", raw_int[0], 0);
        pop_tx();
        chk("R7 tx 3 at thr", raw_int[0], 1);

        // R10 DMA requests
        chk("R10 disabled", {tx_dma_req, rx_dma_req}, 2'b00);
        den_w(2'b10);
        chk("R10 tx enabled", {tx_dma_req, rx_dma_req}, 2'b10);
        den_w(2'b11);
        chk("R10 rx 2 not above 4", rx_dma_req, 0);
        for (int i = 0; i < 3; i++) push_rx(DATA_W'(16'h0F00 + i));
        chk("R10 rx 5 above 4", rx_dma_req, 1);
        for (int i = 0; i < 3; i++) push_tx(DATA_W'(16'h0F10 + i));
        chk("R10 tx 6 above 5", tx_dma_req, 0);
        chk("R10 dma_en readback", dma_en, 2'b11);

        // R8 mask and interrupt line
        mask_w(5'b10001);
        chk("R8 masked", masked_int, 5'b10000);
        chk("R8 irq on", irq, 1);
        mask_w(5'b00001);
        chk("R8 masked off", masked_int, 0);
        chk("R8 irq off", irq, 0);

        // drain with order checks
        repeat (6) pop_tx();
        repeat (5) pop_rx();
        chk("R2 final tx", tx_level, 0);
        chk("R2 final rx", rx_level, 0);
        chk("R2 scoreboards empty", txq.size() + rxq.size(), 0);

        done = 1;
        summary();
    end

endmodule